// File: doc/BRIEF.md
# Parallel Port Strobe Handshake Controller

This block runs an 8-bit parallel port with two strobes: strobe A comes in from the remote party and strobe B goes out to it. A small register interface holds a control byte, a status flag and a data register. The control byte picks the protocol: simple strobe or full handshake, input or output direction, interlocked or pulsed strobe B, which strobe A edge counts, the active level of strobe B, and open-drain (wired-OR) drive.

Strobe A passes through a synchronizer before its edges are detected. A detected edge sets the status flag. In simple mode and in input handshake the same edge latches the port input byte. Strobe B is started by a data register access: a write in simple mode and in output handshake, a read in input handshake. Strobe B then either pulses for a fixed number of cycles or holds until the selected strobe A edge. In output handshake the port drivers are enabled only while strobe A sits at its enabling level. In open-drain mode the drivers pull low only, and a 1 releases the pin.

Top module: `pp_handshake`

## Requirements
- R1: A synchronous active-high reset clears the control byte (reads 0 at address 0), the flag (status reads 0 at address 1) and all output enables, and leaves strobe B high (inactive for active-low polarity).
- R2: The control byte at address 0 reads back as written. Bit0 is open-drain, bit1 is full handshake, bit2 is output direction, bit3 is pulsed, bit4 is rising edge select and bit5 is strobe B active high. Bits 7:6 read 0.
- R3: Only the selected strobe A edge sets status bit0: falling when bit4=0, rising when bit4=1. The flag shows by the fourth clock after the strobe A change.
- R4: In simple mode and in input handshake, the selected edge latches port_in. A read of address 2 returns the latched byte, and later changes of port_in without an edge do not alter it.
- R5: In simple mode (bit1=0), each write to address 2 drives strobe B active for exactly 2 cycles. Bits 2 and 3 are ignored in this mode: no port output enable, and no interlock.
- R6: In pulsed full handshake, strobe B is active for exactly 2 cycles after a read of address 2 (input direction) or a write of address 2 (output direction). A write in input direction does not start strobe B.
- R7: In interlocked full handshake, strobe B stays active from its trigger until the selected strobe A edge is detected. The opposite edge does not end it.
- R8: With bit5=0 strobe B is active low, idling at 1. With bit5=1 it is active high, idling at 0.
- R9: Outside output handshake, port_oe is all zero. In output handshake, port_oe is all ones while strobe A is high (falling edge selected) or low (rising edge selected).
- R10: With bit0=1, each enabled pin has port_out=0 and port_oe set only where the data bit is 0. With bit0=0, port_out carries the data and every enabled pin drives.
- R11: The flag clears only on an access to address 2 that follows a status read which saw the flag set. An access to address 2 without that read leaves the flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data (combinational) |
| strb_a_in | input | 1 | Strobe A from the remote side (asynchronous) |
| strb_b_out | output | 1 | Strobe B to the remote side |
| port_in | input | 8 | Port pin input levels |
| port_out | output | 8 | Port pin output values |
| port_oe | output | 8 | Per-pin output enable |

## Verification
The bench goes after the exact length of the strobe B pulse. A counter off by one would show a pulse of one or three cycles. It checks that an interlocked strobe B survives the unselected strobe A edge and ends on the selected one; a swapped edge decode would end it early or never. It confirms that the flag survives a data read that was not preceded by a status read, which a design clearing on any data access would fail. It also checks that open-drain mode never drives a 1 and that the output enable follows strobe A with the right polarity for each edge setting.

// File: rtl/pp_hs_pkg.sv
package pp_hs_pkg;
   localparam int CTRL_BITS = 6;

   // Control byte; the packed order makes strb_hi bit5 and wired_or bit0.
   typedef struct packed {
      logic strb_hi;
      logic rise_edge;
      logic pulsed;
      logic out_dir;
      logic full_hs;
      logic wired_or;
   } pp_ctrl_t;

   typedef enum logic [1:0] {
      A_CTRL = 2'd0,
      A_STAT = 2'd1,
      A_DATA = 2'd2,
      A_NONE = 2'd3
   } pp_addr_e;

   typedef enum logic [1:0] {
      S_IDLE  = 2'd0,
      S_PULSE = 2'd1,
      S_HOLD  = 2'd2
   } pp_strb_st_e;
endpackage

// File: rtl/pp_hs_sync.sv
module pp_hs_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic async_in,
   input  logic rise_sel,
   output logic level,
   output logic edge_hit
);
   if (STAGES < 2) begin : g_bad_stages
      $error("pp_hs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk) begin
      if (rst) begin
         chain <= '0;
         prev  <= 1'b0;
      end else begin
         chain <= {chain[STAGES-2:0], async_in};
         prev  <= chain[STAGES-1];
      end
   end

   logic rise_seen, fall_seen;
   assign level     = chain[STAGES-1];
   assign rise_seen = level & ~prev;
   assign fall_seen = ~level & prev;
   assign edge_hit  = rise_sel ? rise_seen : fall_seen;

   // R3: a selected edge is never reported for the opposite transition
   p_edge_dir_r3: assert property (@(posedge clk) disable iff (rst)
      edge_hit |-> (rise_sel ? (level && !prev) : (!level && prev)));
endmodule

// File: rtl/pp_hs_strobe.sv
module pp_hs_strobe
   import pp_hs_pkg::*;
#(
   parameter int PULSE_CYC = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig,
   input  logic pulsed_mode,
   input  logic edge_hit,
   output logic active
);
   localparam int CNT_W = (PULSE_CYC > 1) ? $clog2(PULSE_CYC) : 1;

   if (PULSE_CYC < 1) begin : g_bad_pulse
      $error("pp_hs_strobe: PULSE_CYC must be at least 1");
   end

   pp_strb_st_e      st;
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (rst) begin
         st  <= S_IDLE;
         cnt <= '0;
      end else if (trig) begin
         if (pulsed_mode) begin
            st  <= S_PULSE;
            cnt <= CNT_W'(PULSE_CYC - 1);
         end else begin
            st  <= S_HOLD;
            cnt <= '0;
         end
      end else begin
         unique case (st)
            S_PULSE: begin
               if (cnt == '0) st <= S_IDLE;
               else           cnt <= cnt - 1'b1;
            end
            S_HOLD: begin
               if (edge_hit) st <= S_IDLE;
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assign active = (st != S_IDLE);

   // R5 / R6: any trigger starts strobe B on the next cycle
   p_trig_start_r5: assert property (@(posedge clk) disable iff (rst)
      trig |=> active);
   // R6: a pulse ends when its count runs out
   p_pulse_end_r6: assert property (@(posedge clk) disable iff (rst)
      (st == S_PULSE && cnt == '0 && !trig) |=> !active);
   // R7: an interlocked strobe ends only on the selected edge
   p_hold_end_r7: assert property (@(posedge clk) disable iff (rst)
      (st == S_HOLD && edge_hit && !trig) |=> !active);
   p_hold_keep_r7: assert property (@(posedge clk) disable iff (rst)
      (st == S_HOLD && !edge_hit) |=> active);
endmodule

// File: rtl/pp_hs_pad.sv
module pp_hs_pad #(
   parameter int W = 8
) (
   input  logic [W-1:0] data,
   input  logic         drive_en,
   input  logic         wired_or,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe
);
   if (W < 1) begin : g_bad_width
      $error("pp_hs_pad: W must be at least 1");
   end

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_comb begin
         if (wired_or) begin
            pad_out[i] = 1'b0;
            pad_oe[i]  = drive_en & ~data[i];
         end else begin
            pad_out[i] = data[i];
            pad_oe[i]  = drive_en;
         end
      end
   end

   // R10: open-drain pins never drive a high level
   always_comb begin
      if (wired_or) begin
         p_od_no_high_r10: assert ((pad_oe & pad_out) == '0);
      end
   end
endmodule

// File: rtl/pp_handshake.sv
module pp_handshake
   import pp_hs_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int PULSE_CYC   = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        reg_addr,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic              strb_a_in,
   output logic              strb_b_out,
   input  logic [DATA_W-1:0] port_in,
   output logic [DATA_W-1:0] port_out,
   output logic [DATA_W-1:0] port_oe
);
   localparam int PAD_HI = DATA_W - CTRL_BITS;

   if (DATA_W < CTRL_BITS) begin : g_bad_data_w
      $error("pp_handshake: DATA_W too narrow for the control byte");
   end

   pp_ctrl_t          ctrl;
   logic [DATA_W-1:0] out_q, in_q;
   logic              flag, armed;
   logic              lvl, edge_hit, active;

   logic sel_ctrl, sel_stat, sel_data;
   logic data_wr, data_rd, out_hs, trig, pulsed_mode, drive_en;

   assign sel_ctrl = (reg_addr == A_CTRL);
   assign sel_stat = (reg_addr == A_STAT);
   assign sel_data = (reg_addr == A_DATA);
   assign data_wr  = reg_wr & sel_data;
   assign data_rd  = reg_rd & sel_data;
   assign out_hs   = ctrl.full_hs & ctrl.out_dir;

   // Strobe B trigger and mode selection
   always_comb begin
      if (!ctrl.full_hs) begin
         trig        = data_wr;
         pulsed_mode = 1'b1;
      end else begin
         trig        = ctrl.out_dir ? data_wr : data_rd;
         pulsed_mode = ctrl.pulsed;
      end
   end

   assign drive_en   = out_hs & (ctrl.rise_edge ? ~lvl : lvl);
   assign strb_b_out = ctrl.strb_hi ? active : ~active;

   pp_hs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst      (rst),
      .async_in (strb_a_in),
      .rise_sel (ctrl.rise_edge),
      .level    (lvl),
      .edge_hit (edge_hit)
   );

   pp_hs_strobe #(.PULSE_CYC(PULSE_CYC)) u_strobe (
      .clk         (clk),
      .rst         (rst),
      .trig        (trig),
      .pulsed_mode (pulsed_mode),
      .edge_hit    (edge_hit),
      .active      (active)
   );

   pp_hs_pad #(.W(DATA_W)) u_pad (
      .data     (out_q),
      .drive_en (drive_en),
      .wired_or (ctrl.wired_or),
      .pad_out  (port_out),
      .pad_oe   (port_oe)
   );

   // Registers
   always_ff @(posedge clk) begin
      if (rst) begin
         ctrl  <= '0;
         out_q <= '0;
         in_q  <= '0;
      end else begin
         if (reg_wr && sel_ctrl) ctrl <= pp_ctrl_t'(reg_wdata[CTRL_BITS-1:0]);
         if (data_wr)            out_q <= reg_wdata;
         if (edge_hit && !out_hs) in_q <= port_in;
      end
   end

   // Flag with two-step clear; a new edge wins over a clear
   always_ff @(posedge clk) begin
      if (rst) begin
         flag  <= 1'b0;
         armed <= 1'b0;
      end else begin
         if (reg_rd && sel_stat && flag) armed <= 1'b1;
         if ((data_rd || data_wr) && armed) begin
            flag  <= 1'b0;
            armed <= 1'b0;
         end
         if (edge_hit) begin
            flag  <= 1'b1;
            armed <= 1'b0;
         end
      end
   end

   // Read mux
   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         A_CTRL:  reg_rdata = {{PAD_HI{1'b0}}, ctrl};
         A_STAT:  reg_rdata = {{(DATA_W-1){1'b0}}, flag};
         A_DATA:  reg_rdata = out_hs ? out_q : in_q;
         default: reg_rdata = '0;
      endcase
   end

   // R3: a detected edge always leaves the flag set
   p_flag_set_r3: assert property (@(posedge clk) disable iff (rst)
      edge_hit |=> flag);
   // R4: an edge outside output handshake captures the pins
   p_latch_r4: assert property (@(posedge clk) disable iff (rst)
      (edge_hit && !out_hs) |=> (in_q == $past(port_in)));
   // R9: drivers stay off unless in output handshake
   p_oe_mode_r9: assert property (@(posedge clk) disable iff (rst)
      !out_hs |-> (port_oe == '0));
   // R11: the flag never drops without a data register access
   p_flag_hold_r11: assert property (@(posedge clk) disable iff (rst)
      (flag && !data_rd && !data_wr) |=> flag);
endmodule

// File: tb/pp_handshake_test.sv
module pp_handshake_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_wr = 1'b0;
   logic       reg_rd = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       strb_a_in = 1'b0;
   logic       strb_b_out;
   logic [7:0] port_in = 8'h00;
   logic [7:0] port_out;
   logic [7:0] port_oe;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   pp_handshake uut (
      .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .strb_a_in(strb_a_in), .strb_b_out(strb_b_out),
      .port_in(port_in), .port_out(port_out), .port_oe(port_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; strb_a_in = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0;
      repeat (3) @(negedge clk);
      rst = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] v);
      @(negedge clk);
      reg_addr = a; reg_rd = 1'b1;
      #1 v = reg_rdata;
      @(negedge clk);
      reg_rd = 1'b0;
   endtask

   task automatic set_a(input logic v);
      @(negedge clk);
      strb_a_in = v;
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] v;
      do_reset();
      chk("R1 strobe B idle", strb_b_out, 1);
      chk("R1 oe", port_oe, 0);
      rd(2'd0, v); chk("R1 ctrl", v, 0);
      rd(2'd1, v); chk("R1 flag", v, 0);
   endtask

   task automatic t_ctrl_rw();
      logic [7:0] v;
      do_reset();
      wr(2'd0, 8'hFF); rd(2'd0, v); chk("R2 ctrl readback ff", v, 8'h3F);
      wr(2'd0, 8'h2A); rd(2'd0, v); chk("R2 ctrl readback 2a", v, 8'h2A);
   endtask

   task automatic t_edge_select();
      logic [7:0] v;
      do_reset();
      set_a(1'b1);
      rd(2'd1, v); chk("R3 rising ignored when falling selected", v, 0);
      set_a(1'b0);
      rd(2'd1, v); chk("R3 falling sets flag", v, 1);
      do_reset();
      wr(2'd0, 8'h10);
      set_a(1'b1);
      rd(2'd1, v); chk("R3 rising sets flag", v, 1);
   endtask

   task automatic t_simple();
      logic [7:0] v;
      do_reset();
      wr(2'd0, 8'h04);  // direction bit set, interlock, but simple mode
      port_in = 8'h3C;
      wr(2'd2, 8'h55);
      chk("R5 pulse cycle 1", strb_b_out, 0);
      @(negedge clk); chk("R5 pulse cycle 2", strb_b_out, 0);
      @(negedge clk); chk("R5 pulse ended", strb_b_out, 1);
      chk("R5 no oe in simple mode", port_oe, 0);
      set_a(1'b1); set_a(1'b0);
      rd(2'd2, v); chk("R4 simple latch", v, 8'h3C);
      port_in = 8'h99;
      repeat (3) @(negedge clk);
      rd(2'd2, v); chk("R4 latch held without edge", v, 8'h3C);
   endtask

   task automatic t_input_pulsed();
      logic [7:0] v;
      do_reset();
      wr(2'd0, 8'h0A);
      wr(2'd2, 8'h11);
      chk("R6 write does not start strobe in input", strb_b_out, 1);
      port_in = 8'hC3;
      rd(2'd2, v);
      chk("R6 read pulse cycle 1", strb_b_out, 0);
      @(negedge clk); chk("R6 read pulse cycle 2", strb_b_out, 0);
      @(negedge clk); chk("R6 read pulse ended", strb_b_out, 1);
      set_a(1'b1); set_a(1'b0);
      rd(2'd2, v); chk("R4 input handshake latch", v, 8'hC3);
   endtask

   task automatic t_interlock();
      logic [7:0] v;
      do_reset();
      wr(2'd0, 8'h12);  // full, input, interlocked, rising edge
      rd(2'd2, v);
      repeat (6) @(negedge clk);
      chk("R7 held before edge", strb_b_out, 0);
      set_a(1'b1);
      chk("R7 released by rising edge", strb_b_out, 1);
      rd(2'd2, v);
      set_a(1'b0);
      chk("R7 falling edge does not release", strb_b_out, 0);
      set_a(1'b1);
      chk("R7 released again", strb_b_out, 1);
   endtask

   task automatic t_polarity();
      do_reset();
      wr(2'd0, 8'h20);
      chk("R8 active-high idle", strb_b_out, 0);
      wr(2'd2, 8'h01);
      chk("R8 active-high pulse", strb_b_out, 1);
      @(negedge clk); @(negedge clk);
      chk("R8 active-high back to idle", strb_b_out, 0);
   endtask

   task automatic t_output_gate();
      do_reset();
      wr(2'd0, 8'h0E);  // full, output, pulsed, falling edge
      wr(2'd2, 8'hA5);
      chk("R9 oe off while strobe A low", port_oe, 0);
      set_a(1'b1);
      chk("R9 oe on while strobe A high", port_oe, 8'hFF);
      chk("R10 push-pull data", port_out, 8'hA5);
      wr(2'd0, 8'h1E);
      chk("R9 rising select disables at high", port_oe, 0);
      set_a(1'b0);
      chk("R9 rising select enables at low", port_oe, 8'hFF);
      wr(2'd0, 8'h1F);
      chk("R10 open-drain enables zeros only", port_oe, 8'h5A);
      chk("R10 open-drain drives low", port_out, 8'h00);
   endtask

   task automatic t_flag_clear();
      logic [7:0] v;
      do_reset();
      set_a(1'b1); set_a(1'b0);
      rd(2'd2, v);
      rd(2'd1, v); chk("R11 data read alone keeps flag", v, 1);
      rd(2'd2, v);
      rd(2'd1, v); chk("R11 status then data clears", v, 0);
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      t_reset();
      t_ctrl_rw();
      t_edge_select();
      t_simple();
      t_input_pulsed();
      t_interlock();
      t_polarity();
      t_output_gate();
      t_flag_clear();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule